// File: doc/BRIEF.md
# Interpolating I/Q Upconverter

The block takes pairs of signed 16-bit baseband samples (an in-phase value and a quadrature value) that arrive at a low rate. It produces a modulated carrier at a 64 times higher sample rate for an external 8-bit resistor-ladder DAC. Each output sample is paced by a clock-enable divider on the system clock. Between two consecutive input pairs the block interpolates linearly over 64 steps. The interpolated pair then multiplies a fixed quadrature carrier whose period is exactly 32 output samples. The saturated result leaves as an offset-binary byte.

With the default divider of 50 and a 153.6 MHz system clock, output samples arrive at 3.072 MS/s. The carrier then sits at 96 kHz, and the expected input rate is 48 kS/s per channel. Input pairs enter a small FIFO. The producer is never held off: a pair offered while the FIFO is full is discarded. When the interpolator needs a new pair and none is waiting, it substitutes a full-scale in-phase value with zero quadrature, so the DAC carries bare carrier until data resumes.

Top module: `iq_upconverter`

## Requirements
- R1: `dac_strobe` pulses for one cycle exactly every DIV (default 50) clock cycles. The first pulse comes on the DIV-th rising edge after reset is released.
- R2: `dac_out` changes only in the cycle in which `dac_strobe` is high, and holds its value between pulses.
- R3: The carrier phase index starts at 0 after reset and advances by one per output sample, wrapping after 32. Sample n uses cos and sin of 2*pi*idx/32, scaled to an amplitude of 32767.
- R4: With endpoints A (older) and B (newer) and a fraction f that counts 0..63 (0 after reset, +1 per sample), the interpolated value is A + floor((B-A)*f/64), for I and Q separately. When f wraps from 63 to 0, B becomes A and a new B is taken.
- R5: The mixed value is floor((I*cos - Q*sin)/32768), saturated to the range -32768..32767.
- R6: `dac_out` is bits 15..8 of the saturated value with bit 7 inverted (offset binary), so 0 maps to 128, +32767 to 255 and -32768 to 0.
- R7: The input FIFO holds 4 pairs in arrival order. `in_ready` is high while it is not full. A pair offered with `in_valid` while it is full is discarded and never appears in the output.
- R8: If the FIFO is empty when a new endpoint is taken, the endpoint is I=32767, Q=0.
- R9: Synchronous active-high reset sets `dac_out` to 128 and `dac_strobe` to 0, empties the FIFO, and sets both endpoints to I=32767, Q=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An input pair is offered this cycle |
| in_ready | output | 1 | High when an offered pair will be stored |
| in_i | input | 16 | In-phase sample, two's complement |
| in_q | input | 16 | Quadrature sample, two's complement |
| dac_out | output | 8 | Offset-binary DAC code |
| dac_strobe | output | 1 | One-cycle pulse marking a new `dac_out` value |

## Verification
The in-RTL assertions check, on every cycle, the properties that need only a cycle or two of history: a single-cycle strobe, an output that holds between strobes, a carrier index and an interpolation fraction that step once per strobe, the endpoint shift at the wrap, the carrier-only endpoint on underflow, and a FIFO that never grows past its depth or moves its write pointer when a pair is discarded. The arithmetic needs the bench's scenarios. These include the rounding of the interpolation, the shape of the carrier, saturation of the mixed sum at 45-degree phases, and the offset-binary mapping. The bench scenarios also show which pairs survive an overflow burst and in what order, the exact 50-cycle strobe spacing, and the return to clean carrier after draining and after a mid-stream reset.

// File: rtl/iqu_pkg.sv
package iqu_pkg;

  localparam int SAMP_W    = 16;  // baseband sample width
  localparam int COEF_W    = 16;  // carrier coefficient width (table scaled to 32767)
  localparam int CAR_IDX_W = 5;   // 32 carrier points per period (table is fixed to this)

  typedef struct packed {
    logic signed [SAMP_W-1:0] i;
    logic signed [SAMP_W-1:0] q;
  } iq_t;

  localparam logic signed [SAMP_W-1:0] FS_POS = {1'b0, {(SAMP_W-1){1'b1}}};

  localparam iq_t CARRIER_ONLY = '{i: FS_POS, q: '0};

  // Quarter-wave sine, 32767 * sin(k * pi / 16) rounded, k = 0..8
  function automatic logic signed [COEF_W-1:0] quarter_sine(input logic [3:0] k);
    logic signed [COEF_W-1:0] v;
    case (k)
      4'd0:    v = 16'sd0;
      4'd1:    v = 16'sd6393;
      4'd2:    v = 16'sd12539;
      4'd3:    v = 16'sd18204;
      4'd4:    v = 16'sd23170;
      4'd5:    v = 16'sd27245;
      4'd6:    v = 16'sd30273;
      4'd7:    v = 16'sd32137;
      default: v = 16'sd32767;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/iqu_strobe.sv
module iqu_strobe #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + CW'(1);
  end

  // R1: a strobe never lasts two cycles
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/iqu_fifo.sv
module iqu_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push, pop;

  assign full    = (cnt == CNT_FULL);
  assign empty   = (cnt == '0);
  assign push    = wr_en && !full;   // a write while full is dropped
  assign pop     = rd_en && !empty;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PTR_LAST) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == PTR_LAST) ? '0 : rp + AW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R7: occupancy never exceeds the depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_FULL);

  // R7: a write offered while full leaves the store untouched
  a_r7_drop_when_full: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> full && $stable(wp));

endmodule

// File: rtl/iqu_interp.sv
module iqu_interp
  import iqu_pkg::*;
#(
  parameter int PH_BITS = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic fifo_empty,
  input  iq_t  fifo_data,
  output logic pop,
  output iq_t  cur
);
  localparam int PW = SAMP_W + PH_BITS + 2;

  iq_t               ep_a, ep_b;
  logic [PH_BITS-1:0] phase;
  logic               wrap;

  function automatic logic signed [SAMP_W-1:0] lerp(
    input logic signed [SAMP_W-1:0] x0,
    input logic signed [SAMP_W-1:0] x1,
    input logic [PH_BITS-1:0]       f
  );
    logic signed [SAMP_W:0] d;
    logic signed [PW-1:0]   p;
    d = $signed({x1[SAMP_W-1], x1}) - $signed({x0[SAMP_W-1], x0});
    p = PW'(d) * PW'($signed({1'b0, f}));
    p = p >>> PH_BITS;
    return x0 + p[SAMP_W-1:0];
  endfunction

  assign wrap  = adv && (phase == '1);
  assign pop   = wrap && !fifo_empty;
  assign cur.i = lerp(ep_a.i, ep_b.i, phase);
  assign cur.q = lerp(ep_a.q, ep_b.q, phase);

  always_ff @(posedge clk) begin
    if (rst) begin
      ep_a  <= CARRIER_ONLY;
      ep_b  <= CARRIER_ONLY;
      phase <= '0;
    end else if (adv) begin
      phase <= phase + PH_BITS'(1);
      if (wrap) begin
        ep_a <= ep_b;
        ep_b <= fifo_empty ? CARRIER_ONLY : fifo_data;
      end
    end
  end

  // R4: the fraction moves only on a sample strobe
  a_r4_phase_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(phase));

  // R4: at the wrap the newer endpoint becomes the older one
  a_r4_endpoint_shift: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (phase == '0) && (ep_a == $past(ep_b)));

  // R8: starvation loads a full-scale, zero-quadrature endpoint
  a_r8_underflow_carrier: assert property (@(posedge clk) disable iff (rst)
    (wrap && fifo_empty) |=> (ep_b.i == FS_POS) && (ep_b.q == '0));

endmodule

// File: rtl/iqu_carrier.sv
module iqu_carrier
  import iqu_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     adv,
  output logic signed [COEF_W-1:0] cos_c,
  output logic signed [COEF_W-1:0] sin_c
);
  localparam int QW = CAR_IDX_W - 2;            // index bits inside one quadrant
  localparam logic [CAR_IDX_W-1:0] QUARTER = CAR_IDX_W'(2 ** QW);

  logic [CAR_IDX_W-1:0] idx;

  function automatic logic signed [COEF_W-1:0] sine_at(input logic [CAR_IDX_W-1:0] j);
    logic [3:0] k, kr;
    k  = 4'(j[QW-1:0]);
    kr = 4'(2 ** QW) - k;
    case (j[CAR_IDX_W-1 -: 2])
      2'd0:    return quarter_sine(k);
      2'd1:    return quarter_sine(kr);
      2'd2:    return -quarter_sine(k);
      default: return -quarter_sine(kr);
    endcase
  endfunction

  assign sin_c = sine_at(idx);
  assign cos_c = sine_at(idx + QUARTER);

  always_ff @(posedge clk) begin
    if (rst)      idx <= '0;
    else if (adv) idx <= idx + CAR_IDX_W'(1);
  end

  // R3: one carrier step per output sample
  a_r3_index_step: assert property (@(posedge clk) disable iff (rst)
    adv |=> idx == $past(idx) + CAR_IDX_W'(1));

  // R3: no step without a strobe
  a_r3_index_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(idx));

endmodule

// File: rtl/iqu_mixer.sv
module iqu_mixer
  import iqu_pkg::*;
#(
  parameter int OUT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  iq_t                      smp,
  input  logic signed [COEF_W-1:0] cos_c,
  input  logic signed [COEF_W-1:0] sin_c,
  output logic [OUT_W-1:0]         dac_out,
  output logic                     dac_strobe
);
  localparam int PROD_W = SAMP_W + COEF_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((2 ** (SAMP_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] SAT_LO = -SUM_W'(2 ** (SAMP_W - 1));
  localparam logic [OUT_W-1:0] MID_CODE = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [PROD_W-1:0] p_c, p_s;
  logic signed [SUM_W-1:0]  sum, scaled;
  logic signed [SAMP_W-1:0] sat;
  logic [OUT_W-1:0]         code;

  always_comb begin
    p_c    = PROD_W'(smp.i) * PROD_W'(cos_c);
    p_s    = PROD_W'(smp.q) * PROD_W'(sin_c);
    sum    = SUM_W'(p_c) - SUM_W'(p_s);
    scaled = sum >>> (COEF_W - 1);
    if (scaled > SAT_HI)      sat = SAT_HI[SAMP_W-1:0];
    else if (scaled < SAT_LO) sat = SAT_LO[SAMP_W-1:0];
    else                      sat = scaled[SAMP_W-1:0];
    code = {~sat[SAMP_W-1], sat[SAMP_W-2 -: OUT_W-1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_out    <= MID_CODE;
      dac_strobe <= 1'b0;
    end else begin
      dac_strobe <= load;
      if (load) dac_out <= code;
    end
  end

  // R2: the DAC code holds between strobes
  a_r2_hold_between: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(dac_out));

  // R2: the strobe marks exactly the cycle after a load
  a_r2_strobe_follows: assert property (@(posedge clk) disable iff (rst)
    load |=> dac_strobe);

endmodule

// File: rtl/iq_upconverter.sv
module iq_upconverter
  import iqu_pkg::*;
#(
  parameter int DIV        = 50,
  parameter int FIFO_DEPTH = 4,
  parameter int PH_BITS    = 6,
  parameter int OUT_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SAMP_W-1:0] in_i,
  input  logic [SAMP_W-1:0] in_q,
  output logic [OUT_W-1:0]  dac_out,
  output logic              dac_strobe
);
  localparam int PAIR_W = $bits(iq_t);

  logic               tick;
  logic               fifo_empty, fifo_full, pop;
  logic [PAIR_W-1:0]  fifo_rd;
  iq_t                cur;
  logic signed [COEF_W-1:0] cos_c, sin_c;

  assign in_ready = !fifo_full;

  iqu_strobe #(.DIV(DIV)) u_strobe (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  iqu_fifo #(.DEPTH(FIFO_DEPTH), .W(PAIR_W)) u_fifo (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (in_valid),
    .wr_data({in_i, in_q}),
    .rd_en  (pop),
    .rd_data(fifo_rd),
    .empty  (fifo_empty),
    .full   (fifo_full)
  );

  iqu_interp #(.PH_BITS(PH_BITS)) u_interp (
    .clk       (clk),
    .rst       (rst),
    .adv       (tick),
    .fifo_empty(fifo_empty),
    .fifo_data (iq_t'(fifo_rd)),
    .pop       (pop),
    .cur       (cur)
  );

  iqu_carrier u_carrier (
    .clk  (clk),
    .rst  (rst),
    .adv  (tick),
    .cos_c(cos_c),
    .sin_c(sin_c)
  );

  iqu_mixer #(.OUT_W(OUT_W)) u_mixer (
    .clk       (clk),
    .rst       (rst),
    .load      (tick),
    .smp       (cur),
    .cos_c     (cos_c),
    .sin_c     (sin_c),
    .dac_out   (dac_out),
    .dac_strobe(dac_strobe)
  );

  // R7: no pair is taken from the FIFO while it is empty
  a_r7_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
    fifo_empty |-> !pop);

endmodule

// File: tb/iq_upconverter_bench.sv
module iq_upconverter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 50;
  localparam int DEPTH      = 4;
  localparam int NVEC       = 6;
  localparam int VEC_I [NVEC] = '{0, 16384, 0, 32767, -32768, -12000};
  localparam int VEC_Q [NVEC] = '{0, 0, 16384, -32767, 32767, 8000};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_i = '0, in_q = '0;
  logic [7:0]  dac_out;
  logic        dac_strobe;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  string cur_req = "R9";

  // reference model state
  int mq_i[$], mq_q[$];
  int m_ai, m_aq, m_bi, m_bq, m_ph, m_idx, m_gap, m_last;

  always #(CLK_PERIOD/2) clk = ~clk;

  iq_upconverter u_iq_upconverter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .dac_out(dac_out), .dac_strobe(dac_strobe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expect_code(int ai, int aq, int bi, int bq, int ph, int idx);
    int   vi, vq, v;
    real  th, m;
    vi = ai + (((bi - ai) * ph) >>> 6);
    vq = aq + (((bq - aq) * ph) >>> 6);
    th = 2.0 * 3.14159265358979 * idx / 32.0;
    m  = (vi * 32767.0 * $cos(th) - vq * 32767.0 * $sin(th)) / 32768.0;
    v  = int'($floor(m));
    if (v > 32767)  v = 32767;
    if (v < -32768) v = -32768;
    return (v >>> 8) + 128;
  endfunction

  // Reference model: inputs sampled at the edge, outputs read shortly after it
  always @(posedge clk) begin
    bit pv, prst;
    int pi, pq, pre, exp, act;
    pv = in_valid; prst = rst;
    pi = int'($signed(in_i)); pq = int'($signed(in_q));
    #2;
    if (prst) begin
      mq_i.delete(); mq_q.delete();
      m_ai = 32767; m_aq = 0; m_bi = 32767; m_bq = 0;
      m_ph = 0; m_idx = 0; m_gap = 0; m_last = 128;
    end else begin
      pre = mq_i.size();
      m_gap++;
      if (dac_strobe) begin
        chk(m_gap == DIV, "R1", "strobe spacing", m_gap, DIV);
        m_gap = 0;
        exp = expect_code(m_ai, m_aq, m_bi, m_bq, m_ph, m_idx);
        act = int'(dac_out);
        chk((act - exp <= 1) && (exp - act <= 1),
            {cur_req, " R3 R4 R5 R6"}, "dac code", act, exp);
        if (m_ph == 63) begin
          m_ai = m_bi; m_aq = m_bq;
          if (pre > 0) begin
            m_bi = mq_i.pop_front(); m_bq = mq_q.pop_front();
          end else begin
            m_bi = 32767; m_bq = 0;   // R8 carrier-only endpoint
          end
        end
        m_ph  = (m_ph + 1) % 64;
        m_idx = (m_idx + 1) % 32;
      end else begin
        chk(int'(dac_out) == m_last, "R2", "hold between strobes", int'(dac_out), m_last);
      end
      m_last = int'(dac_out);
      if (pv && pre < DEPTH) begin
        mq_i.push_back(pi); mq_q.push_back(pq);
      end
    end
  end

  task automatic push_pair(input int vi, input int vq);
    in_valid = 1'b1; in_i = 16'(vi); in_q = 16'(vq);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_samples(input int n);
    repeat (n * DIV) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(dac_out == 8'h80, "R9", "reset dac_out", int'(dac_out), 128);
    chk(dac_strobe == 1'b0, "R9", "reset strobe", int'(dac_strobe), 0);
    chk(in_ready == 1'b1, "R9", "reset in_ready", int'(in_ready), 1);
    rst = 1'b0;

    // start-up with no data: bare carrier
    cur_req = "R8";
    wait_samples(70);

    // vector table, offered only while there is room
    cur_req = "R4";
    for (int k = 0; k < NVEC; k++) begin
      while (!in_ready) @(negedge clk);
      push_pair(VEC_I[k], VEC_Q[k]);
    end
    wait_samples(5 * 64);
    cur_req = "R8";
    wait_samples(3 * 64);

    // overflow burst: back-to-back offers regardless of ready
    cur_req = "R7";
    in_valid = 1'b1;
    for (int k = 0; k < NVEC; k++) begin
      in_i = 16'(VEC_I[NVEC-1-k]); in_q = 16'(VEC_Q[NVEC-1-k]);
      @(negedge clk);
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk(in_ready == (mq_i.size() < DEPTH), "R7", "in_ready after burst",
        int'(in_ready), int'(mq_i.size() < DEPTH));
    chk(mq_i.size() <= DEPTH, "R7", "model occupancy bound", mq_i.size(), DEPTH);
    wait_samples(6 * 64);

    // reset in mid-stream
    cur_req = "R9";
    push_pair(20000, -20000);
    push_pair(-5000, 30000);
    wait_samples(100);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(dac_out == 8'h80, "R9", "mid-stream reset dac_out", int'(dac_out), 128);
    chk(dac_strobe == 1'b0, "R9", "mid-stream reset strobe", int'(dac_strobe), 0);
    chk(in_ready == 1'b1, "R9", "mid-stream reset in_ready", int'(in_ready), 1);
    rst = 1'b0;
    wait_samples(80);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule